// File: doc/BRIEF.md
# Cascadable Segment Driver Core

This block is the digital core of a dot-matrix display segment driver. It has two serial shift chains of equal length, and each chain has its own serial input and its own tap output. The two chains can be fed separately. They can also be joined by routing the first tap into the second input, which forms one chain twice as long. The second tap lets a further core be chained after this one, so that a wider panel can be driven.

A shift strobe moves data along both chains. A separate transfer enable copies the full set of chain bits into a segment latch. Each latched bit is then combined with an alternating polarity input to choose one of four drive levels for its segment. Each level is given as a 2-bit code.

The whole block runs in one system-clock domain:
- The shift strobe is sampled, and a detected high-to-low transition acts as the shift enable.
- The transfer enable is level-sensitive. The latch captures on every clock edge at which the enable is high.
- The level codes are registered, so they follow the latch and polarity inputs one cycle later.

Top module: `seg_drive_core`

## Requirements
- R1: A synchronous active-high reset clears both chains, the segment latch and the strobe history. While reset is held, both taps read 0 and every segment code reads 00. On the first edge after reset is released, every code becomes the unselected code for the current polarity.
- R2: A shift happens only at a clock edge where `shift_strb_i` is sampled 0 and was sampled 1 at the previous edge. A steady strobe or a rising strobe leaves both chains unchanged, whatever the serial inputs do.
- R3: On each shift, `ser_a_i` enters the first stage of chain A. A bit reaches `tap_a_o`, the last stage of chain A, after 20 shifts.
- R4: Chain B is independent of chain A. It is fed from `ser_b_i`, and a bit reaches `tap_b_o` after 20 shifts.
- R5: When `tap_a_o` is wired to `ser_b_i`, the two chains behave as one 40-stage chain. The first bit shifted in appears at `tap_b_o` after exactly 40 shifts.
- R6: At each edge where `xfer_en_i` is high, the latch takes the chain contents held before that edge's shift. While `xfer_en_i` is low, the latch holds its value, and shifting does not alter any segment code.
- R7: The level codes are 00 for the top supply, 01 for the first intermediate level, 10 for the second intermediate level and 11 for the bottom supply. A latched 1 gives 11 when `alt_i` is 0 and 00 when `alt_i` is 1. A latched 0 gives 01 when `alt_i` is 0 and 10 when `alt_i` is 1.
- R8: Segment n (1..40) drives `seg_lvl_o[2n-1:2n-2]`.
  - Segments 1..20 are stages 1..20 of chain A.
  - Segments 21..40 are stages 1..20 of chain B.
  - After 20 shifts of d1..d20 into chain A, segment k shows d(21-k).
- R9: The codes are registered. A change of `alt_i` with the latch steady changes every segment code one cycle later. A transfer shows on the codes one cycle after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_strb_i | input | 1 | Shift strobe; a falling transition shifts both chains |
| xfer_en_i | input | 1 | Transfer enable for the segment latch (level-sensitive) |
| alt_i | input | 1 | Alternating drive polarity |
| ser_a_i | input | 1 | Serial input of chain A (segments 1..20) |
| ser_b_i | input | 1 | Serial input of chain B (segments 21..40) |
| tap_a_o | output | 1 | Last stage of chain A |
| tap_b_o | output | 1 | Last stage of chain B |
| seg_lvl_o | output | 80 | Two-bit level code per segment |

## Verification
The hardest situation to reach from the ports is the cascaded mode. In it, chain B is fed through the registered tap of chain A while the latch captures in the same cycle as a shift. Only then do the ordering of capture against shift and the tap's one-stage delay both matter.

The bench routes `tap_a_o` back into `ser_b_i` inside the bench. It first runs a directed 40-shift walk of a single 1 bit. It then runs long seeded random runs that switch between the split and cascaded modes and fire transfers at random, including on shifting edges. A cycle-accurate model in the bench compares every tap and segment code after every edge.

// File: rtl/seg_drive_pkg.sv
package seg_drive_pkg;

  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_TOP  = 2'b00,
    LVL_MID1 = 2'b01,
    LVL_MID2 = 2'b10,
    LVL_BOT  = 2'b11
  } lvl_e;

  // Selected segments swing between the rails, unselected ones between
  // the intermediate levels; polarity picks the phase.
  function automatic lvl_e lvl_pick(input logic on, input logic alt);
    if (on) return alt ? LVL_TOP : LVL_BOT;
    else    return alt ? LVL_MID2 : LVL_MID1;
  endfunction

endpackage

// File: rtl/seg_fall_det.sv
module seg_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // R2: two shifts can never happen on consecutive edges
  p_no_double_shift_r2: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
  parameter int DEPTH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] stages_o,
  output logic             tap_o
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst)           stg_q <= '0;
    else if (shift_en) stg_q <= {stg_q[LAST-1:0], din};
  end

  assign stages_o = stg_q;
  assign tap_o    = stg_q[LAST];

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stg_q));

  p_enter_r3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stg_q[0] == $past(din));

  p_tap_step_r3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> tap_o == $past(stg_q[LAST-1]));

endmodule

// File: rtl/seg_out_latch.sv
module seg_out_latch #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst)     q_q <= '0;
    else if (en) q_q <= d;
  end

  assign q = q_q;

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    en |=> q == $past(d));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
  import seg_drive_pkg::*;
#(
  parameter int NSEG = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSEG-1:0]       on_i,
  input  logic                  alt_i,
  output logic [NSEG*LVL_W-1:0] lvl_o
);

  logic [NSEG*LVL_W-1:0] lvl_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) lvl_q[g*LVL_W +: LVL_W] <= '0;
      else     lvl_q[g*LVL_W +: LVL_W] <= lvl_pick(on_i[g], alt_i);
    end
  end

  assign lvl_o = lvl_q;

  // R7: a selected segment always sits on a rail, an unselected one never does
  p_rail_sel_r7: assert property (@(posedge clk) disable iff (rst)
    on_i[0] |=> (lvl_o[1:0] == 2'b00 || lvl_o[1:0] == 2'b11));

  p_mid_unsel_r7: assert property (@(posedge clk) disable iff (rst)
    !on_i[0] |=> (lvl_o[1:0] == 2'b01 || lvl_o[1:0] == 2'b10));

endmodule

// File: rtl/seg_drive_core.sv
module seg_drive_core
  import seg_drive_pkg::*;
#(
  parameter int CHAIN_LEN = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift_strb_i,
  input  logic                      xfer_en_i,
  input  logic                      alt_i,
  input  logic                      ser_a_i,
  input  logic                      ser_b_i,
  output logic                      tap_a_o,
  output logic                      tap_b_o,
  output logic [2*CHAIN_LEN*2-1:0]  seg_lvl_o
);

  localparam int NCHAIN = 2;
  localparam int NSEG   = NCHAIN * CHAIN_LEN;

  logic              shift_en;
  logic [NCHAIN-1:0] ser_in;
  logic [NCHAIN-1:0] taps;
  logic [NSEG-1:0]   chain_bits;
  logic [NSEG-1:0]   latched;

  assign ser_in = {ser_b_i, ser_a_i};

  seg_fall_det u_fall (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (shift_strb_i),
    .fall_o (shift_en)
  );

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    seg_shift_chain #(.DEPTH(CHAIN_LEN)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .din      (ser_in[c]),
      .stages_o (chain_bits[c*CHAIN_LEN +: CHAIN_LEN]),
      .tap_o    (taps[c])
    );
  end

  assign tap_a_o = taps[0];
  assign tap_b_o = taps[1];

  seg_out_latch #(.W(NSEG)) u_latch (
    .clk (clk),
    .rst (rst),
    .en  (xfer_en_i),
    .d   (chain_bits),
    .q   (latched)
  );

  seg_level_enc #(.NSEG(NSEG)) u_enc (
    .clk   (clk),
    .rst   (rst),
    .on_i  (latched),
    .alt_i (alt_i),
    .lvl_o (seg_lvl_o)
  );

  // R9: flipping polarity with a steady latch changes every code next cycle
  p_alt_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (latched == $past(latched) && alt_i != $past(alt_i) && !$past(rst))
      |=> seg_lvl_o[1:0] != $past(seg_lvl_o[1:0]));

  // R1: taps are clear in the cycle after reset
  p_reset_taps_r1: assert property (@(posedge clk)
    rst |=> (!tap_a_o && !tap_b_o));

endmodule

// File: tb/seg_drive_core_tb_top.sv
module seg_drive_core_tb_top;
  import seg_drive_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int L = 20;
  localparam int N = 2 * L;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sc = 1'b0, le = 1'b0, al = 1'b0, da = 1'b0, db_drv = 1'b0, casc = 1'b0;
  logic ser_b;
  logic tap_a, tap_b;
  logic [2*N-1:0] seg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [L-1:0]   mA, mB;
  logic [N-1:0]   mL;
  logic [2*N-1:0] mS;
  logic           mPrev;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ser_b = casc ? tap_a : db_drv;

  seg_drive_core #(.CHAIN_LEN(L)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .shift_strb_i (sc),
    .xfer_en_i    (le),
    .alt_i        (al),
    .ser_a_i      (da),
    .ser_b_i      (ser_b),
    .tap_a_o      (tap_a),
    .tap_b_o      (tap_b),
    .seg_lvl_o    (seg)
  );

  function automatic logic [1:0] code_of(input logic on, input logic a);
    if (on) return a ? 2'b00 : 2'b11;
    return a ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update for one edge, using the values driven for that edge
  task automatic model_edge();
    logic fall, bin;
    if (rst) begin
      mA = '0; mB = '0; mL = '0; mS = '0; mPrev = 1'b0;
    end else begin
      for (int k = 0; k < N; k++) mS[2*k +: 2] = code_of(mL[k], al);
      if (le) mL = {mB, mA};
      fall = mPrev & ~sc;
      mPrev = sc;
      bin = casc ? mA[L-1] : db_drv;
      if (fall) begin
        mA = {mA[L-2:0], da};
        mB = {mB[L-2:0], bin};
      end
    end
  endtask

  // inputs change at the falling clock edge; compare after the next rising edge
  task automatic tick(input string tag, input logic s, input logic l,
                      input logic a, input logic x, input logic y);
    sc = s; le = l; al = a; da = x; db_drv = y;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " seg"}, seg, mS);
    chk({tag, " tapA"}, {{(2*N-1){1'b0}}, tap_a}, {{(2*N-1){1'b0}}, mA[L-1]});
    chk({tag, " tapB"}, {{(2*N-1){1'b0}}, tap_b}, {{(2*N-1){1'b0}}, mB[L-1]});
  endtask

  task automatic shift_bit(input string tag, input logic a, input logic x, input logic y);
    tick(tag, 1'b1, 1'b0, a, x, y);
    tick(tag, 1'b0, 1'b0, a, x, y);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick("R1 reset", 1'b0, 1'b0, al, 1'b0, 1'b0);
    tick("R1 reset", 1'b0, 1'b0, al, 1'b0, 1'b0);
    chk("R1 reset codes zero", seg, '0);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] pat;
    logic [1:0]   exp2;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R1: the first edge after reset gives unselected codes for the polarity
    tick("R1 release", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 unselected after release", seg, {N{2'b01}});

    // R2: steady and rising strobe with toggling data shifts nothing
    for (int i = 0; i < 6; i++) tick("R2 steady low", 1'b0, 1'b0, 1'b0, i[0], ~i[0]);
    for (int i = 0; i < 6; i++) tick("R2 steady high", 1'b1, 1'b0, 1'b0, ~i[0], i[0]);
    tick("R2 latch after no shift", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    tick("R2 codes", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R2 chains untouched", seg, {N{2'b01}});

    // R3/R8/R6: feed a pattern into chain A, latch low while shifting
    pat = 20'hB3A17;
    for (int i = 0; i < L; i++) shift_bit("R3 fill A", 1'b0, pat[L-1-i], 1'b0);
    chk("R6 no change while latch low", seg, {N{2'b01}});
    tick("R6 transfer", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick("R9 transfer shows", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    exp2 = code_of(pat[L-1], 1'b0);
    chk("R8 segment 20 holds first bit", {{(2*N-2){1'b0}}, seg[2*L-1 -: 2]}, {{(2*N-2){1'b0}}, exp2});
    exp2 = code_of(pat[0], 1'b0);
    chk("R8 segment 1 holds last bit", {{(2*N-2){1'b0}}, seg[1:0]}, {{(2*N-2){1'b0}}, exp2});

    // R7/R9: polarity toggles with a steady latch
    tick("R7 alt high", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    tick("R9 alt flip", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick("R7 alt high again", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R4: chain B fed alone
    for (int i = 0; i < L; i++) shift_bit("R4 fill B", 1'b1, 1'b0, i[1]);
    tick("R4 transfer", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    tick("R4 codes", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R5: cascade walk of a single 1 through 40 stages
    do_reset();
    casc = 1'b1;
    shift_bit("R5 cascade", 1'b0, 1'b1, 1'b0);
    for (int i = 1; i < N; i++) begin
      shift_bit("R5 cascade", 1'b0, 1'b0, 1'b0);
      if (i == N - 2) chk("R5 tapB low before 40", {{(2*N-1){1'b0}}, tap_b}, '0);
    end
    chk("R5 tapB after 40 shifts", {{(2*N-1){1'b0}}, tap_b}, {{(2*N-1){1'b0}}, 1'b1});

    // mixed random run covering all requirements against the model
    for (int blk = 0; blk < 8; blk++) begin
      casc = blk[0];
      for (int i = 0; i < 1500; i++)
        tick("R2 R3 R4 R5 R6 R7 random", ($urandom % 3) != 0, ($urandom % 8) == 0,
             ($urandom % 16) == 0 ? ~al : al, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule